// File: doc/BRIEF.md
# Power Mode Controller

This block holds the byte-wide power-control register of an 8051-style core and drives the pins that depend on it. The core writes the register through a simple special-function-register write port at one fixed address. The register value then selects one of three operating states: normal run, Idle and Power-down. In each state the block drives the address-latch strobe, the program-store strobe and the output selection of port 0 and port 2. The pin levels depend on whether code runs from internal or external program memory.

The block also handles the watchdog-load-enable flag. Software sets the flag before a reload. A reload strobe from the watchdog is accepted only while the flag is set, and an accepted reload clears the flag. A strobe that arrives while the flag is clear is rejected with a pulse. The baud-doubling bit and the auxiliary-RAM-disable bit leave the block as plain levels. Two further bits are free software flags. An interrupt request ends Idle. Only reset ends Power-down.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is active, and on the first cycle after it, the register reads 8'h00 and the block is in normal run: idle=0 and pdown=0.
- R2: A write is taken only when sfr_we=1 and sfr_addr=8'h87. Such a write replaces all 8 bits. sfr_rdata shows the register when sfr_addr=8'h87 and shows 8'h00 otherwise. Writes are ignored while Idle or Power-down is active.
- R3: The register bits are: 7 = baud double, 6 = aux-RAM disable, 5 = ALE quiet, 4 = watchdog-load enable, 3 and 2 = general flags, 1 = Power-down, 0 = Idle. When bit 1 is set, pdown=1 and idle=0, even if bit 0 is also set. When bit 0 is set alone, idle=1.
- R4: In Idle, ale=1 and psen=1. p0_float and p2_addr both equal ext_code.
- R5: In Power-down, ale=0, psen=0 and p2_addr=0. p0_float equals ext_code.
- R6: In normal run, psen follows psen_core, p0_float=0 and p2_addr equals ext_code. ale follows ale_core while bit 5 is 0 and is held at 0 while bit 5 is 1.
- R7: irq=1 during Idle clears bit 0 at the next clock. irq has no effect on Power-down, which only reset ends.
- R8: wdt_strobe=1 while bit 4 is 1 gives wdt_load=1 in the same cycle, and bit 4 reads 0 on the next cycle. If an accepted register write comes in the same cycle, the written value wins.
- R9: wdt_strobe=1 while bit 4 is 0 gives wdt_reject=1 and wdt_load=0, and changes no register bit.
- R10: smod equals bit 7 and aux_ram_off equals bit 6. Bits 3 and 2 are stored and read back, and they affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, 0 when not addressed |
| irq | input | 1 | Interrupt request, ends Idle |
| ext_code | input | 1 | 1 = code runs from external program memory |
| ale_core | input | 1 | Address-latch strobe from the core |
| psen_core | input | 1 | Program-store strobe from the core |
| wdt_strobe | input | 1 | Watchdog reload strobe |
| wdt_load | output | 1 | Reload accepted |
| wdt_reject | output | 1 | Reload rejected |
| ale | output | 1 | Address-latch pin level |
| psen | output | 1 | Program-store pin level |
| p0_float | output | 1 | Port 0 floats |
| p2_addr | output | 1 | Port 2 drives address (0 = port data) |
| idle | output | 1 | Idle active |
| pdown | output | 1 | Power-down active |
| smod | output | 1 | Baud-double level |
| aux_ram_off | output | 1 | Auxiliary RAM disabled |

## Verification
The assertions assume that every input is a clean 0 or 1, sampled once per clock. They also assume that a register write and an interrupt request each act for exactly the cycle they are high. The bench drives all inputs on the falling edge with definite values only. Because Power-down cannot be left without reset, the bench applies reset between stimulus rounds. A random round therefore cannot get stuck in Power-down and leave the other paths unexercised.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter logic [7:0] ADDR = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       irq,
  input  logic       ext_code,
  input  logic       ale_core,
  input  logic       psen_core,
  input  logic       wdt_strobe,
  output logic       wdt_load,
  output logic       wdt_reject,
  output logic       ale,
  output logic       psen,
  output logic       p0_float,
  output logic       p2_addr,
  output logic       idle,
  output logic       pdown,
  output logic       smod,
  output logic       aux_ram_off
);
  localparam int B_PD  = 1;
  localparam int B_IDL = 0;
  localparam int B_WLE = 4;
  localparam int B_RFI = 5;

  logic [7:0] pcon;
  logic       hit, wr;

  assign hit   = (sfr_addr == ADDR);
  assign pdown = pcon[B_PD];
  assign idle  = pcon[B_IDL] & ~pcon[B_PD];
  assign wr    = sfr_we & hit & ~(idle | pdown);

  assign wdt_load   = wdt_strobe & pcon[B_WLE];
  assign wdt_reject = wdt_strobe & ~pcon[B_WLE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcon <= 8'h00;
    end else if (wr) begin
      pcon <= sfr_wdata;
    end else begin
      if (wdt_load) pcon[B_WLE] <= 1'b0;
      if (idle && irq) pcon[B_IDL] <= 1'b0;
    end
  end

  assign sfr_rdata   = hit ? pcon : 8'h00;
  assign smod        = pcon[7];
  assign aux_ram_off = pcon[6];

  always_comb begin
    if (pdown) begin
      ale = 1'b0;
      psen = 1'b0;
    end else if (idle) begin
      ale = 1'b1;
      psen = 1'b1;
    end else begin
      ale = pcon[B_RFI] ? 1'b0 : ale_core;
      psen = psen_core;
    end
  end

  assign p0_float = (idle | pdown) & ext_code;
  assign p2_addr  = ext_code & ~pdown;
endmodule

module pwr_mode_ctl_chk #(
  parameter logic [7:0] ADDR = 8'h87
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_we,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] pcon,
  input logic       irq,
  input logic       wdt_strobe,
  input logic       wdt_load,
  input logic       ale,
  input logic       psen,
  input logic       idle,
  input logic       pdown
);
  // R3
  pd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == ADDR && sfr_wdata[1] && !idle && !pdown) |=> (pdown && !idle));
  // R7
  pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |=> pdown);
  // R7
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && irq) |=> !idle);
  // R5
  pd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |-> (!ale && !psen));
  // R4
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (ale && psen));
  // R8
  wle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_load && !(sfr_we && sfr_addr == ADDR && !idle && !pdown)) |=> !pcon[4]);
  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_strobe && !pcon[4] && !sfr_we && !irq) |=> $stable(pcon));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.ADDR(ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .pcon(pcon), .irq(irq), .wdt_strobe(wdt_strobe),
  .wdt_load(wdt_load), .ale(ale), .psen(psen), .idle(idle), .pdown(pdown)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic sfr_we = 0, irq = 0, ext_code = 0, ale_core = 0, psen_core = 0, wdt_strobe = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0;
  logic [7:0] sfr_rdata;
  logic wdt_load, wdt_reject, ale, psen, p0_float, p2_addr, idle, pdown, smod, aux_ram_off;
  int tests = 0, fails = 0;
  int m = 0;

  always #5 clk = ~clk;

  pwr_mode_ctl u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic st, input logic ir, input logic ac,
                      input logic pc, input logic ex);
    int pd, il, e_idle, e_ale, e_psen, nxt;
    sfr_we = we; sfr_addr = a; sfr_wdata = d; wdt_strobe = st;
    irq = ir; ale_core = ac; psen_core = pc; ext_code = ex;
    #1;
    pd = (m >> 1) & 1;
    il = m & 1;
    e_idle = il & ~pd & 1;
    if (pd != 0) begin e_ale = 0; e_psen = 0; end
    else if (e_idle != 0) begin e_ale = 1; e_psen = 1; end
    else begin e_ale = ((m >> 5) & 1) != 0 ? 0 : int'(ac); e_psen = int'(pc); end
    chk("R2 rdata", sfr_rdata, (a == 8'h87) ? m : 0);
    chk("R3 pdown", pdown, pd);
    chk("R3 idle", idle, e_idle);
    chk("R4/R5/R6 ale", ale, e_ale);
    chk("R4/R5/R6 psen", psen, e_psen);
    chk("R4/R5/R6 p0_float", p0_float, ((pd != 0) || (e_idle != 0)) ? int'(ex) : 0);
    chk("R4/R5/R6 p2_addr", p2_addr, (pd != 0) ? 0 : int'(ex));
    chk("R8 wdt_load", wdt_load, (st && ((m >> 4) & 1) != 0) ? 1 : 0);
    chk("R9 wdt_reject", wdt_reject, (st && ((m >> 4) & 1) == 0) ? 1 : 0);
    chk("R10 smod", smod, (m >> 7) & 1);
    chk("R10 aux_ram_off", aux_ram_off, (m >> 6) & 1);
    nxt = m;
    if (!rst_n) nxt = 0;
    else if (we && a == 8'h87 && pd == 0 && e_idle == 0) nxt = int'(d);
    else begin
      if (st && ((m >> 4) & 1) != 0) nxt = nxt & ~32'h10;
      if (e_idle != 0 && ir) nxt = nxt & ~32'h01;
    end
    @(posedge clk);
    m = nxt;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic ex);
    step(1, 8'h87, d, 0, 0, 1, 1, ex);
  endtask

  task automatic idle_cyc(input logic ex);
    step(0, 8'h87, 8'h00, 0, 0, 1, 1, ex);
  endtask

  task automatic do_reset;
    rst_n = 0;
    idle_cyc(0);
    idle_cyc(1);
    rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state, also driven with a write during reset
    rst_n = 0;
    step(1, 8'h87, 8'hFF, 0, 0, 1, 1, 0);
    rst_n = 1;
    idle_cyc(0);
    chk("R1 rdata after reset", sfr_rdata, 8'h00);
    // R2 wrong address ignored
    step(1, 8'h86, 8'hA5, 0, 0, 0, 0, 0);
    chk("R2 other address", sfr_rdata, 8'h00);
    // R10 flags and levels
    wr(8'hCC, 0);
    chk("R10 readback", sfr_rdata, 8'hCC);
    step(0, 8'h87, 8'h00, 0, 0, 1, 0, 1);
    // R6 ALE quiet
    wr(8'h20, 0);
    step(0, 8'h87, 8'h00, 0, 0, 1, 1, 0);
    chk("R6 ale held", ale, 0);
    // R8 and R9
    wr(8'h10, 0);
    step(0, 8'h87, 8'h00, 1, 0, 1, 1, 0);
    chk("R8 wle cleared", sfr_rdata[4], 0);
    step(0, 8'h87, 8'h00, 1, 0, 1, 1, 0);
    // R8 write wins against load
    wr(8'h10, 0);
    step(1, 8'h87, 8'h14, 1, 0, 1, 1, 0);
    chk("R8 write wins", sfr_rdata, 8'h14);
    // R4 and R7 idle entry, write ignored, irq exit
    wr(8'h01, 1);
    chk("R4 idle", idle, 1);
    step(1, 8'h87, 8'h00, 0, 0, 0, 0, 1);
    chk("R2 write ignored in idle", sfr_rdata, 8'h01);
    step(0, 8'h87, 8'h00, 0, 1, 0, 0, 1);
    chk("R7 idle exit", idle, 0);
    // R3 and R5 both bits, irq no effect
    wr(8'h03, 1);
    chk("R3 pd priority", pdown, 1);
    step(0, 8'h87, 8'h00, 0, 1, 1, 1, 1);
    step(0, 8'h87, 8'h00, 0, 1, 1, 1, 0);
    chk("R7 pd stays", pdown, 1);
    do_reset();
    chk("R1 pd left by reset", pdown, 0);

    for (int r = 0; r < 10; r++) begin
      do_reset();
      for (int c = 0; c < 300; c++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (($urandom % 8) != 0) d[1] = 1'b0;
        if (($urandom % 3) != 0) d[0] = 1'b0;
        step(($urandom % 4) == 0,
             (($urandom % 2) == 0) ? 8'h87 : 8'($urandom),
             d, ($urandom % 4) == 0, ($urandom % 6) == 0,
             1'($urandom), 1'($urandom), 1'($urandom));
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule